// File: doc/BRIEF.md
# Split Result Register With Read Lock

This block stores a 10-bit conversion result and presents it to software as two bytes over an 8-bit read port. Because one result needs two reads, a newer result could otherwise land between them and leave software with a low byte from one conversion and a high byte from another. The block prevents this. A read of the low byte locks the stored word. A read of the high byte releases it. Any result that arrives while the word is locked is dropped.

The block also keeps a conversion-complete flag. The flag is raised for every result pulse, including pulses whose data was dropped, so software still learns that a conversion finished. A level interrupt request combines the flag with an enable. Software clears the flag with a strobe.

The result input is a valid-only stream with no back-pressure. Every pulse of `res_valid` is taken in the cycle it is seen. It is either stored or deliberately discarded, and the source never waits. The read strobes, the clear strobe and the enable are plain control pins. Read data is combinational in the cycle of the strobe.

Top module: `split_result_latch`

## Requirements
- R1: After reset the stored word is zero, the register is unlocked, the flag is 0 and `irq` is 0.
- R2: A `res_valid` pulse while unlocked, with neither read strobe active in that cycle, stores `res_data`; from the next cycle a low-byte read returns bits 7..0.
- R3: A high-byte read (`rd_hi`=1, `rd_lo`=0) returns the stored bits 9..8 in `rd_data[1:0]`, with `rd_data[7:2]` equal to zero.
- R4: A low-byte read locks the register. While locked, no `res_valid` pulse changes either byte.
- R5: A high-byte read with `rd_lo`=0 unlocks the register, so the next `res_valid` pulse is stored again.
- R6: When `res_valid` comes in the same cycle as either read strobe, the read returns the old byte and the new result is discarded.
- R7: Every `res_valid` pulse sets the flag from the next cycle, whether its result was stored or discarded.
- R8: A `flag_clr` pulse clears the flag in the next cycle. If `res_valid` is 1 in the same cycle, the flag is set instead.
- R9: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1.
- R10: A high-byte read with no low-byte read before it returns the current contents and leaves the register unlocked.
- R11: `rd_data` is zero when neither strobe is active. When both strobes are 1 in the same cycle, this counts as a low-byte read: the low byte is returned and the register locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle pulse marking a finished conversion |
| res_data | input | 10 | Conversion result that accompanies `res_valid` |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Byte selected by the active strobe, or zero |
| flag_clr | input | 1 | Clears the completion flag |
| irq_en | input | 1 | Interrupt enable |
| irq_flag | output | 1 | Conversion-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the cycles where a result pulse lands in the same cycle as a read. A design that writes before it decides the lock would let a high byte from a newer result pair with an older low byte. It also targets results that arrive during the lock. A design that updates even one byte here, or that forgets to raise the flag for a discarded result, shows wrong data or a missing flag on the next read. Three further cases are covered:
- a high-byte read with no low-byte read before it, which a wrong design would treat as a lock;
- both strobes together;
- a clear that collides with a new result, where a wrong design would lose the interrupt.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int unsigned RES_W = 10;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } byte_sel_e;
endpackage

// File: rtl/srl_lock_ctrl.sv
module srl_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic res_valid,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic locked,
  output logic wr_en,
  output srl_pkg::byte_sel_e sel
);
  import srl_pkg::*;

  logic lock_q;
  logic any_read;

  assign any_read = rd_lo | rd_hi;

  always_comb begin
    if (rd_lo)      sel = SEL_LO;
    else if (rd_hi) sel = SEL_HI;
    else            sel = SEL_NONE;
  end

  // A result is stored only while unlocked and when no read is in flight.
  assign wr_en = res_valid & ~lock_q & ~any_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (rd_lo) lock_q <= 1'b1;
    else if (rd_hi) lock_q <= 1'b0;
  end

  assign locked = lock_q;
endmodule

// File: rtl/srl_result_store.sv
module srl_result_store #(
  parameter int unsigned W = srl_pkg::RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end

  assign word = word_q;
endmodule

// File: rtl/srl_byte_mux.sv
module srl_byte_mux #(
  parameter int unsigned RW = srl_pkg::RES_W,
  parameter int unsigned BW = srl_pkg::BUS_W
) (
  input  logic [RW-1:0]      word,
  input  srl_pkg::byte_sel_e sel,
  output logic [BW-1:0]      rd_data
);
  import srl_pkg::*;

  localparam int unsigned HI_W = RW - BW;

  logic [BW-1:0] lo_byte;
  logic [BW-1:0] hi_byte;

  assign lo_byte = word[BW-1:0];

  // The upper part of the word goes to the lowest bits of the high byte.
  // Every remaining bit of the high byte is zero.
  generate
    if (HI_W < BW) begin : g_pad
      assign hi_byte = {{(BW-HI_W){1'b0}}, word[RW-1:BW]};
    end else begin : g_full
      assign hi_byte = word[RW-1:BW];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_LO:  rd_data = lo_byte;
      SEL_HI:  rd_data = hi_byte;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/srl_irq_flag.sv
module srl_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic req
);
  logic flag_q;

  // When set and clear arrive together, set wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign req  = flag_q & en;
endmodule

// File: rtl/split_result_latch.sv
module split_result_latch #(
  parameter int unsigned RES_W = srl_pkg::RES_W,
  parameter int unsigned BUS_W = srl_pkg::BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [BUS_W-1:0] rd_data,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic             irq_flag,
  output logic             irq
);
  import srl_pkg::*;

  logic             locked;
  logic             wr_en;
  byte_sel_e        sel;
  logic [RES_W-1:0] res_word;

  srl_lock_ctrl u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .locked    (locked),
    .wr_en     (wr_en),
    .sel       (sel)
  );

  srl_result_store #(.W(RES_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (res_data),
    .word    (res_word)
  );

  srl_byte_mux #(.RW(RES_W), .BW(BUS_W)) u_mux (
    .word    (res_word),
    .sel     (sel),
    .rd_data (rd_data)
  );

  srl_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (res_valid),
    .clr   (flag_clr),
    .en    (irq_en),
    .flag  (irq_flag),
    .req   (irq)
  );
endmodule

// File: rtl/split_result_latch_chk.sv
module split_result_latch_chk #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic             rd_lo,
  input logic             rd_hi,
  input logic [BUS_W-1:0] rd_data,
  input logic             flag_clr,
  input logic             irq_flag,
  input logic             locked,
  input logic [RES_W-1:0] res_word
);
  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !locked && !rd_lo && !rd_hi) |=> (res_word == $past(res_data)));

  p_hi_zero_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) |-> (rd_data[BUS_W-1:RES_W-BUS_W] == '0));

  p_lock_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> locked);

  p_lock_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(res_word));

  p_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) |=> !locked);

  p_same_cycle_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo || rd_hi) |=> $stable(res_word));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> irq_flag);

  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !res_valid) |=> !irq_flag);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |-> (rd_data == '0));
endmodule

bind split_result_latch split_result_latch_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_data  (res_data),
  .rd_lo     (rd_lo),
  .rd_hi     (rd_hi),
  .rd_data   (rd_data),
  .flag_clr  (flag_clr),
  .irq_flag  (irq_flag),
  .locked    (locked),
  .res_word  (res_word)
);

// File: tb/split_result_latch_bench.sv
module split_result_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic       flag_clr = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_flag;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Behavioural reference state
  int m_word = 0;
  bit m_lock = 0;
  bit m_flag = 0;

  always #5 clk = ~clk;

  split_result_latch u_split_result_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .rd_data   (rd_data),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .irq_flag  (irq_flag),
    .irq       (irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare outputs, then advance the model at posedge.
  task automatic step(input bit v, input int d, input bit lo, input bit hi,
                      input bit clr, input bit en, input string tag);
    int exp_rd;
    @(negedge clk);
    res_valid = v; res_data = d[9:0]; rd_lo = lo; rd_hi = hi;
    flag_clr = clr; irq_en = en;
    #1;
    if (lo)      exp_rd = m_word % 256;
    else if (hi) exp_rd = m_word / 256;
    else         exp_rd = 0;
    check(tag, int'(rd_data), exp_rd);
    check("R7 flag", int'(irq_flag), int'(m_flag));
    check("R9 irq", int'(irq), int'(m_flag && en));
    @(posedge clk);
    if (v && !m_lock && !lo && !hi) m_word = d % 1024;
    if (lo)      m_lock = 1;
    else if (hi) m_lock = 0;
    if (v)        m_flag = 1;
    else if (clr) m_flag = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: state after reset
    step(0, 0, 0, 0, 0, 1, "R1 idle");
    step(0, 0, 1, 0, 0, 1, "R1 lo");
    step(0, 0, 0, 1, 0, 1, "R1 hi");
    // R2, R3: store and read both bytes
    step(1, 'h2A5, 0, 0, 0, 1, "R2 write");
    step(0, 0, 1, 0, 0, 1, "R2 lo");
    step(0, 0, 0, 1, 0, 1, "R3 hi");
    // R8: clear the flag, with irq enabled and disabled
    step(0, 0, 0, 0, 1, 0, "R8 clr");
    step(0, 0, 0, 0, 0, 1, "R9 idle");
    // R4: lock, then results arrive and are dropped, R7 flag still rises
    step(1, 'h3FF, 0, 0, 0, 1, "R2 write2");
    step(0, 0, 1, 0, 1, 1, "R4 lo");
    step(1, 'h100, 0, 0, 0, 1, "R4 drop");
    step(0, 0, 0, 0, 1, 1, "R7 clr");
    step(1, 'h055, 0, 0, 0, 0, "R4 drop2");
    step(0, 0, 1, 0, 0, 1, "R4 lo again");
    step(0, 0, 0, 1, 0, 1, "R5 hi unlock");
    // R5: unlocked again, new value stored
    step(1, 'h15A, 0, 0, 0, 1, "R5 write");
    step(0, 0, 1, 0, 0, 1, "R5 lo");
    step(0, 0, 0, 1, 0, 1, "R5 hi");
    // R6: result pulse in the same cycle as a read
    step(1, 'h0F0, 1, 0, 0, 1, "R6 lo+valid");
    step(1, 'h1E1, 0, 1, 0, 1, "R6 hi+valid");
    step(0, 0, 1, 0, 0, 1, "R6 lo after");
    step(0, 0, 0, 1, 0, 1, "R6 hi after");
    step(1, 'h222, 0, 1, 0, 1, "R6 hi+valid unlocked");
    step(0, 0, 1, 0, 0, 1, "R6 lo unchanged");
    step(0, 0, 0, 1, 0, 1, "R6 hi unchanged");
    // R8: set wins over clear
    step(1, 'h201, 0, 0, 1, 1, "R8 set+clr");
    step(0, 0, 0, 0, 0, 1, "R8 after");
    step(0, 0, 0, 0, 1, 1, "R8 clr");
    step(0, 0, 0, 0, 0, 1, "R8 cleared");
    // R10: lone high read keeps the register open
    step(0, 0, 0, 1, 0, 1, "R10 lone hi");
    step(1, 'h3C3, 0, 0, 0, 1, "R10 write");
    step(0, 0, 1, 0, 0, 1, "R10 lo");
    step(0, 0, 0, 1, 0, 1, "R10 hi");
    // R11: both strobes act as a low read and lock
    step(0, 0, 1, 1, 0, 1, "R11 both");
    step(1, 'h011, 0, 0, 0, 1, "R11 drop");
    step(0, 0, 0, 1, 0, 1, "R11 hi");
    step(0, 0, 1, 0, 0, 1, "R11 lo");
    step(0, 0, 0, 1, 0, 1, "R11 hi2");
    step(0, 0, 0, 0, 0, 0, "R11 idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule